// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

The tracker runs beside the datapath of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each instruction carries a small record through the pipeline: a valid bit, a cause code and its restart PC pair. Any stage can raise a fault against the instruction it holds. The raised cause is only recorded. Nothing is acted on until the instruction reaches the end of the memory stage. This gives a single commit point, so a fault raised early by a younger instruction can never overtake a fault raised later by an older one.

When a tagged instruction reaches the end of the memory stage, the tracker reports the cause and the restart PC pair. In the same cycle it blocks the memory write and the later register write of that instruction, and it turns every younger instruction into a bubble. External interrupts enter at fetch as marked no-op slots. Each such slot displaces the fetched instruction and takes that instruction's PC. The restart pair is normally (PC, PC+step). For an instruction in a branch delay slot, the second PC is the branch target when the branch is taken, and the slot PC plus step when it is not.

Top module: `exc_tracker`

## Requirements
- R1: While reset is asserted, and after its release with an empty pipeline, exc_valid, mem_commit and wb_commit are 0, even when mem_fault is 1.
- R2: A fault-free instruction fetched in cycle t asserts mem_commit in cycle t+3 and wb_commit in cycle t+4.
- R3: A faulting instruction fetched in cycle t is reported in cycle t+3 with exc_valid=1, exc_pc0 = its PC and, outside a delay slot, exc_pc1 = its PC + 4.
- R4: Cause codes on exc_cause: 1 = fetch fault (if_fault in fetch), 5 = trap (id_trap in decode), 2 = arithmetic (ex_arith in execute), 3 = memory fault (mem_fault in memory). 0 means none and 4 means interrupt.
- R5: When a stage raises a fault for an instruction that already carries a cause, the earlier cause is kept.
- R6: The reported instruction never asserts mem_commit or wb_commit. No instruction fetched after it commits, and no further exception is reported in the next cycle.
- R7: Every instruction older than the reported one commits at both mem_commit and wb_commit, including the one in writeback during the report.
- R8: While irq_req is high and no interrupt slot is in flight, the fetch entry becomes an interrupt slot with cause 4 and PC if_pc. The displaced instruction never commits, and the slot is reported three cycles later.
- R9: At most one interrupt slot is in flight. If it is flushed by an older exception and irq_req is still high, a new slot is inserted in the cycle after the report.
- R10: For the instruction in decode while a valid branch is in execute (ex_branch=1), exc_pc1 is ex_target if ex_taken=1 and its PC + 4 otherwise.
- R11: If an older instruction faults in memory while a younger one faults in an earlier stage in the same cycle, only the older one is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch stage presents an instruction |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_fault | input | 1 | Fetch translation fault for that instruction |
| irq_req | input | 1 | Level external interrupt request |
| id_trap | input | 1 | Decode stage instruction is a trap |
| ex_arith | input | 1 | Execute stage arithmetic fault |
| ex_branch | input | 1 | Execute stage holds a resolved branch |
| ex_taken | input | 1 | That branch is taken |
| ex_target | input | PC_W | Target of that branch |
| mem_fault | input | 1 | Memory stage translation fault |
| mem_commit | output | 1 | Memory stage instruction may write state |
| wb_commit | output | 1 | Writeback stage instruction may write registers |
| exc_valid | output | 1 | Exception reported this cycle |
| exc_cause | output | 3 | Cause code of the reported exception |
| exc_pc0 | output | PC_W | First restart PC |
| exc_pc1 | output | PC_W | Second restart PC |

## Verification
The exception report, the restart pair and mem_commit are combinational on the memory-stage record. They are therefore due in the cycle three clock edges after the instruction's fetch cycle, and wb_commit is due one edge later. The bench drives each stage's fault input in the exact cycle the victim occupies that stage: fetch at t, decode at t+1, execute at t+2, memory at t+3. It samples one time step after the falling edge, records the cycle of every report, and compares it with the arithmetic expectation t+3. Commit pulses are totalled over each run and compared with the number of instructions older than the victim.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE  = 3'd0,
      CAUSE_FETCH = 3'd1,
      CAUSE_ARITH = 3'd2,
      CAUSE_MEM   = 3'd3,
      CAUSE_IRQ   = 3'd4,
      CAUSE_TRAP  = 3'd5
   } cause_e;

   // earliest-raised cause wins
   function automatic cause_e keep_first(cause_e held, logic raise, cause_e fresh);
      if (held != CAUSE_NONE) return held;
      return raise ? fresh : CAUSE_NONE;
   endfunction
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
   import exc_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill,
   input  logic            in_valid,
   input  cause_e          in_cause,
   input  logic [PC_W-1:0] in_pc,
   input  logic [PC_W-1:0] in_npc,
   input  logic            raise,
   input  cause_e          raise_cause,
   output logic            q_valid,
   output cause_e          q_cause,
   output logic [PC_W-1:0] q_pc,
   output logic [PC_W-1:0] q_npc
);
   cause_e merged;

   always_comb merged = in_valid ? keep_first(in_cause, raise, raise_cause) : CAUSE_NONE;

   always_ff @(posedge clk) begin
      if (!rst_n || kill) begin
         q_valid <= 1'b0;
         q_cause <= CAUSE_NONE;
         q_pc    <= '0;
         q_npc   <= '0;
      end else begin
         q_valid <= in_valid;
         q_cause <= merged;
         q_pc    <= in_pc;
         q_npc   <= in_npc;
      end
   end

   // R5
   cause_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill && in_valid && in_cause != CAUSE_NONE) |=> (q_cause == $past(in_cause)));
endmodule

// File: rtl/exc_restart_pair.sv
module exc_restart_pair #(
   parameter int PC_W       = 32,
   parameter bit DELAY_SLOT = 1'b1
) (
   input  logic [PC_W-1:0] seq_npc,
   input  logic            slot,
   input  logic            taken,
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] npc
);
   generate
      if (DELAY_SLOT) begin : g_slot
         always_comb npc = (slot && taken) ? target : seq_npc;
      end else begin : g_plain
         logic unused_in;
         always_comb unused_in = slot ^ taken ^ (^target);
         always_comb npc = seq_npc;
      end
   endgenerate
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
   import exc_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int STEP       = 4,
   parameter bit DELAY_SLOT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            if_valid,
   input  logic [PC_W-1:0] if_pc,
   input  logic            if_fault,
   input  logic            irq_req,
   input  logic            id_trap,
   input  logic            ex_arith,
   input  logic            ex_branch,
   input  logic            ex_taken,
   input  logic [PC_W-1:0] ex_target,
   input  logic            mem_fault,
   output logic            mem_commit,
   output logic            wb_commit,
   output logic            exc_valid,
   output logic [2:0]      exc_cause,
   output logic [PC_W-1:0] exc_pc0,
   output logic [PC_W-1:0] exc_pc1
);
   localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

   generate
      if (PC_W < 4)                    begin : g_bad_w    $error("PC_W too small");       end
      if (STEP < 1 || (STEP & (STEP - 1)) != 0) begin : g_bad_step $error("STEP must be a power of two"); end
   endgenerate

   logic            irq_busy, irq_ins;
   logic            f_valid;
   cause_e          f_cause;
   logic            id_v, ex_v, mem_v, wb_v;
   cause_e          id_c, ex_c, mem_c, fin_c;
   logic [PC_W-1:0] id_pc, ex_pc, mem_pc;
   logic [PC_W-1:0] id_npc, ex_npc, mem_npc, pair_npc;

   // interrupt slot insertion at fetch
   always_comb begin
      irq_ins = irq_req && !irq_busy && !exc_valid;
      f_valid = if_valid || irq_ins;
      f_cause = irq_ins ? CAUSE_IRQ : CAUSE_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         irq_busy <= 1'b0;
      else if (exc_valid) irq_busy <= 1'b0;
      else if (irq_ins)   irq_busy <= 1'b1;
   end

   exc_stage_reg #(.PC_W(PC_W)) u_id (
      .clk(clk), .rst_n(rst_n), .kill(exc_valid),
      .in_valid(f_valid), .in_cause(f_cause), .in_pc(if_pc), .in_npc(if_pc + STEP_V),
      .raise(if_fault && !irq_ins), .raise_cause(CAUSE_FETCH),
      .q_valid(id_v), .q_cause(id_c), .q_pc(id_pc), .q_npc(id_npc));

   exc_restart_pair #(.PC_W(PC_W), .DELAY_SLOT(DELAY_SLOT)) u_pair (
      .seq_npc(id_npc), .slot(ex_branch && ex_v), .taken(ex_taken),
      .target(ex_target), .npc(pair_npc));

   exc_stage_reg #(.PC_W(PC_W)) u_ex (
      .clk(clk), .rst_n(rst_n), .kill(exc_valid),
      .in_valid(id_v), .in_cause(id_c), .in_pc(id_pc), .in_npc(pair_npc),
      .raise(id_trap), .raise_cause(CAUSE_TRAP),
      .q_valid(ex_v), .q_cause(ex_c), .q_pc(ex_pc), .q_npc(ex_npc));

   exc_stage_reg #(.PC_W(PC_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .kill(exc_valid),
      .in_valid(ex_v), .in_cause(ex_c), .in_pc(ex_pc), .in_npc(ex_npc),
      .raise(ex_arith), .raise_cause(CAUSE_ARITH),
      .q_valid(mem_v), .q_cause(mem_c), .q_pc(mem_pc), .q_npc(mem_npc));

   // single commit point at the end of the memory stage
   always_comb begin
      fin_c      = mem_v ? keep_first(mem_c, mem_fault, CAUSE_MEM) : CAUSE_NONE;
      exc_valid  = mem_v && (fin_c != CAUSE_NONE);
      exc_cause  = fin_c;
      exc_pc0    = mem_pc;
      exc_pc1    = mem_npc;
      mem_commit = mem_v && !exc_valid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wb_v <= 1'b0;
      else        wb_v <= mem_v && !exc_valid;
   end
   assign wb_commit = wb_v;

   // R6
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (!exc_valid && !mem_commit && !id_v && !ex_v));

   // R9
   one_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({id_v && id_c == CAUSE_IRQ, ex_v && ex_c == CAUSE_IRQ,
                  mem_v && mem_c == CAUSE_IRQ}) <= 1);

   // R8
   irq_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_v && mem_c == CAUSE_IRQ) |-> (exc_valid && !mem_commit));

   // R6
   wb_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> !wb_commit);
endmodule

// File: tb/sim_exc_tracker.sv
module sim_exc_tracker;
   localparam int PC_W = 16;
   localparam int BASE = 16'h0100;
   localparam int TGT  = 16'h0800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic if_valid = 0, if_fault = 0, irq_req = 0, id_trap = 0, ex_arith = 0;
   logic ex_branch = 0, ex_taken = 0, mem_fault = 0;
   logic [PC_W-1:0] if_pc = '0, ex_target = '0;
   logic mem_commit, wb_commit, exc_valid;
   logic [2:0] exc_cause;
   logic [PC_W-1:0] exc_pc0, exc_pc1;

   int n_chk = 0, n_fail = 0;
   int n_exc, n_mc, n_wc;
   int r_cyc[4], r_cause[4], r_pc0[4], r_pc1[4];

   always #5 clk = ~clk;

   exc_tracker #(.PC_W(PC_W), .STEP(4), .DELAY_SLOT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc), .if_fault(if_fault),
      .irq_req(irq_req), .id_trap(id_trap), .ex_arith(ex_arith), .ex_branch(ex_branch),
      .ex_taken(ex_taken), .ex_target(ex_target), .mem_fault(mem_fault),
      .mem_commit(mem_commit), .wb_commit(wb_commit), .exc_valid(exc_valid),
      .exc_cause(exc_cause), .exc_pc0(exc_pc0), .exc_pc1(exc_pc1));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      if_valid = 0; if_fault = 0; irq_req = 0; id_trap = 0; ex_arith = 0;
      ex_branch = 0; ex_taken = 0; mem_fault = 0; if_pc = '0; ex_target = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      idle_inputs();
      mem_fault = 1;
      repeat (2) @(negedge clk);
      #1;
      check("R1 reset exc_valid", exc_valid, 0);
      check("R1 reset mem_commit", mem_commit, 0);
      check("R1 reset wb_commit", wb_commit, 0);
      @(negedge clk);
      rst_n = 1;
      #1;
      check("R1 empty exc_valid", exc_valid, 0);
      check("R1 empty mem_commit", mem_commit, 0);
      mem_fault = 0;
   endtask

   // -1 disables an event; irq high for ion <= cyc < ioff
   task automatic run(input int ff, input int tr, input int ar, input int mf,
                      input int ion, input int ioff, input int br, input bit tk,
                      input int stop, input int ncyc);
      do_reset();
      n_exc = 0; n_mc = 0; n_wc = 0;
      for (int cyc = 0; cyc < ncyc; cyc++) begin
         if_valid  = (cyc <= stop);
         if_pc     = PC_W'(BASE + 4 * cyc);
         if_fault  = (cyc == ff);
         id_trap   = (cyc == tr);
         ex_arith  = (cyc == ar);
         mem_fault = (cyc == mf);
         irq_req   = (cyc >= ion) && (cyc < ioff);
         ex_branch = (cyc == br);
         ex_taken  = tk;
         ex_target = PC_W'(TGT);
         #1;
         if (exc_valid) begin
            if (n_exc < 4) begin
               r_cyc[n_exc] = cyc; r_cause[n_exc] = int'(exc_cause);
               r_pc0[n_exc] = int'(exc_pc0); r_pc1[n_exc] = int'(exc_pc1);
            end
            n_exc++;
         end
         if (mem_commit) n_mc++;
         if (wb_commit)  n_wc++;
         @(negedge clk);
      end
      idle_inputs();
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int causes[4];
      causes[0] = 1; causes[1] = 5; causes[2] = 2; causes[3] = 3;

      // sweep: stage kind x victim index (R2, R3, R4, R6, R7)
      for (int kind = 0; kind < 4; kind++) begin
         for (int f = 0; f < 4; f++) begin
            run(kind == 0 ? f : -1, kind == 1 ? f + 1 : -1, kind == 2 ? f + 2 : -1,
                kind == 3 ? f + 3 : -1, -1, -1, -1, 0, f + 3, f + 10);
            check("R6 single report", n_exc, 1);
            check("R3 report cycle", r_cyc[0], f + 3);
            check("R4 cause", r_cause[0], causes[kind]);
            check("R3 pc0", r_pc0[0], BASE + 4 * f);
            check("R3 pc1", r_pc1[0], BASE + 4 * f + 4);
            check("R7 R2 mem commits", n_mc, f);
            check("R7 R2 wb commits", n_wc, f);
         end
      end

      // R2 clean stream
      run(-1, -1, -1, -1, -1, -1, -1, 0, 5, 12);
      check("R2 no report", n_exc, 0);
      check("R2 mem commits", n_mc, 6);
      check("R2 wb commits", n_wc, 6);

      // R5 fetch fault kept over later arithmetic fault
      run(1, -1, 3, -1, -1, -1, -1, 0, 4, 10);
      check("R5 fetch kept", r_cause[0], 1);
      // R5 trap kept over later memory fault
      run(-1, 2, -1, 4, -1, -1, -1, 0, 4, 10);
      check("R5 trap kept", r_cause[0], 5);
      check("R5 pc0", r_pc0[0], BASE + 4);

      // R11 older memory fault beats younger arith and fetch faults
      run(3, -1, 4, 4, -1, -1, -1, 0, 4, 12);
      check("R11 single report", n_exc, 1);
      check("R11 cause", r_cause[0], 3);
      check("R11 pc0", r_pc0[0], BASE + 4);
      check("R11 commits", n_mc, 1);

      // R10 delay slot, taken and not taken
      run(-1, -1, -1, 6, -1, -1, 4, 1, 6, 12);
      check("R10 taken pc0", r_pc0[0], BASE + 12);
      check("R10 taken pc1", r_pc1[0], TGT);
      check("R10 older commit", n_mc, 3);
      run(-1, -1, -1, 6, -1, -1, 4, 0, 6, 12);
      check("R10 not taken pc1", r_pc1[0], BASE + 16);

      // R8 interrupt slot
      run(-1, -1, -1, -1, 2, 6, -1, 0, 5, 12);
      check("R8 single report", n_exc, 1);
      check("R8 cycle", r_cyc[0], 5);
      check("R8 cause", r_cause[0], 4);
      check("R8 pc0", r_pc0[0], BASE + 8);
      check("R8 pc1", r_pc1[0], BASE + 12);
      check("R8 displaced not committed", n_mc, 2);
      check("R8 wb commits", n_wc, 2);

      // R9 interrupt slot flushed by older fault, then reinserted
      run(-1, -1, -1, 4, 2, 9, -1, 0, 4, 14);
      check("R9 two reports", n_exc, 2);
      check("R9 first cause", r_cause[0], 3);
      check("R9 first cycle", r_cyc[0], 4);
      check("R9 second cycle", r_cyc[1], 8);
      check("R9 second cause", r_cause[1], 4);
      check("R9 second pc0", r_pc0[1], BASE + 20);
      check("R9 commits", n_mc, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule